// File: doc/BRIEF.md
# Self-Selecting Parallel Host Bus Slave

This block is the host-facing end of a peripheral. It serves a 16-byte register file over an 8-bit parallel bus. The host talks to it with a chip select, a read strobe and a write strobe, all active low, plus an address-latch-enable line. The block works out by itself which kind of bus the host has. One kind carries the register address on four separate address lines. The other kind multiplexes the address onto the data lines and marks it with the latch-enable pulse.

The block comes up in separate-address (direct) mode. It moves to multiplexed mode when it sees latch enable rise. It goes back to direct mode when chip select is released. All host pins are sampled by the block clock through two-flop synchronizers, and every edge is detected on the synchronized copies. The data bus is split into an input, an output and an output enable, so the pad ring can build the tristate driver. The enable is high only while the host is reading.

Top module: `pbus_slave`

## Requirements
- R1: While `rst` is high and right after it: `mode_o` is 0 (direct), `data_oe_o` and `wr_pulse_o` are 0, and all 16 registers read as 0x00.
- R2: While `mode_o` is 0, `reg_addr_o` follows `addr_i`, two clock cycles late. If `ale_i` never rises, `mode_o` stays 0.
- R3: A rising edge on `ale_i` sets `mode_o` to 1 (multiplexed). The change appears three clock edges after the pin changes.
- R4: A rising edge on `cs_n_i` (chip select released) sets `mode_o` back to 0. If a latch-enable rise is detected in the same cycle, the mode becomes 1.
- R5: In multiplexed mode, `reg_addr_o` is the value `data_i[3:0]` held when `ale_i` fell. `data_i[7:4]` is ignored for addressing.
- R6: The address is captured on a falling `ale_i` whatever the level of `cs_n_i`.
- R7: A register is written exactly once per write strobe, when `wr_n_i` rises while `cs_n_i` is low. `wr_pulse_o` is high for one cycle with the register address on `reg_addr_o` and the data on `wr_data_o`.
- R8: A write strobe that ends while `cs_n_i` is high writes nothing and raises no `wr_pulse_o`.
- R9: `data_oe_o` is 1 only while `cs_n_i` and `rd_n_i` are both low (after synchronization). While it is 1, `data_o` holds the register at `reg_addr_o`.
- R10: `data_oe_o` rises on the second rising clock edge after `cs_n_i` and `rd_n_i` go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| ale_i | input | 1 | Address latch enable from host |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| addr_i | input | 4 | Separate address lines |
| data_i | input | 8 | Data bus, input side |
| data_o | output | 8 | Data bus, output side |
| data_oe_o | output | 1 | Output enable for the data pads |
| mode_o | output | 1 | 0 direct, 1 multiplexed |
| reg_addr_o | output | 4 | Register address in use |
| wr_data_o | output | 8 | Write data |
| wr_pulse_o | output | 1 | One-cycle register write pulse |

## Verification
The timing assertions assume that each host pin holds its level for at least three clock cycles. They also assume that address and data lines are stable around the strobe edges that use them. Under those conditions the fixed synchronizer latency maps every pin event onto a known output cycle. The stimulus obeys this: every task changes at most a few pins on a falling clock edge and then waits three or more cycles. The one intentional exception drives a latch-enable rise and a chip-select release on the same edge, to exercise the priority in R4.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    localparam int HOST_DATA_W = 8;
    localparam int HOST_ADDR_W = 4;
    localparam int SYNC_DEPTH  = 2;

    typedef enum logic {
        BUS_DIRECT = 1'b0,
        BUS_MUXED  = 1'b1
    } bus_mode_e;

    // Edge events seen on synchronized, active-high host controls
    typedef struct packed {
        logic ale_rise;
        logic ale_fall;
        logic sel_drop;
        logic wr_end;
    } bus_events_t;

    // Next mode: latch-enable activity outranks a chip-select release
    function automatic bus_mode_e next_mode(bus_mode_e cur, bus_events_t ev);
        if (ev.ale_rise)
            return BUS_MUXED;
        if (ev.sel_drop)
            return BUS_DIRECT;
        return cur;
    endfunction

endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++)
                chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++)
                chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pbus_edge.sv
module pbus_edge #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= '0;
        else     lvl_q <= lvl;
    end

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_bit
            assign rise[g] =  lvl[g] & ~lvl_q[g];
            assign fall[g] = ~lvl[g] &  lvl_q[g];
        end
    endgenerate
endmodule

// File: rtl/pbus_mode_ctrl.sv
module pbus_mode_ctrl
    import pbus_pkg::*;
#(
    parameter int ADDR_W = HOST_ADDR_W,
    parameter int DATA_W = HOST_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_events_t       ev,
    input  logic [ADDR_W-1:0] pin_addr,
    input  logic [DATA_W-1:0] pin_data,
    output bus_mode_e         mode,
    output logic [ADDR_W-1:0] eff_addr
);
    bus_mode_e         mode_q;
    logic [ADDR_W-1:0] mux_addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= BUS_DIRECT;
            mux_addr_q <= '0;
        end else begin
            mode_q <= next_mode(mode_q, ev);
            if (ev.ale_fall)
                mux_addr_q <= pin_data[ADDR_W-1:0];
        end
    end

    assign mode     = mode_q;
    assign eff_addr = (mode_q == BUS_MUXED) ? mux_addr_q : pin_addr;
endmodule

// File: rtl/pbus_regfile.sv
module pbus_regfile #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/pbus_slave.sv
module pbus_slave
    import pbus_pkg::*;
#(
    parameter int DATA_W = HOST_DATA_W,
    parameter int ADDR_W = HOST_ADDR_W,
    parameter int STAGES = SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ale_i,
    input  logic              cs_n_i,
    input  logic              rd_n_i,
    input  logic              wr_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    output logic              mode_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              wr_pulse_o
);
    localparam int CTL_W = 4;
    localparam int BUS_W = ADDR_W + DATA_W;
    localparam int EDG_W = 3;

    // control bit order inside the synchronized vector
    localparam int C_ALE = 3;
    localparam int C_SEL = 2;
    localparam int C_RD  = 1;
    localparam int C_WR  = 0;

    logic [CTL_W-1:0]  ctl_s;
    logic [BUS_W-1:0]  bus_s;
    logic [EDG_W-1:0]  edg_rise, edg_fall;
    logic [ADDR_W-1:0] addr_s, eff_addr;
    logic [DATA_W-1:0] data_s, rdata;
    bus_events_t       ev;
    bus_mode_e         mode;
    logic              commit;

    pbus_sync #(.WIDTH(CTL_W), .STAGES(STAGES)) u_ctl_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ale_i, ~cs_n_i, ~rd_n_i, ~wr_n_i}),
        .q   (ctl_s)
    );

    pbus_sync #(.WIDTH(BUS_W), .STAGES(STAGES)) u_bus_sync (
        .clk (clk),
        .rst (rst),
        .d   ({addr_i, data_i}),
        .q   (bus_s)
    );

    assign addr_s = bus_s[BUS_W-1:DATA_W];
    assign data_s = bus_s[DATA_W-1:0];

    pbus_edge #(.WIDTH(EDG_W)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  ({ctl_s[C_ALE], ctl_s[C_SEL], ctl_s[C_WR]}),
        .rise (edg_rise),
        .fall (edg_fall)
    );

    always_comb begin
        ev.ale_rise = edg_rise[2];
        ev.ale_fall = edg_fall[2];
        ev.sel_drop = edg_fall[1];
        ev.wr_end   = edg_fall[0] & ctl_s[C_SEL];
    end

    pbus_mode_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mode (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .pin_addr (addr_s),
        .pin_data (data_s),
        .mode     (mode),
        .eff_addr (eff_addr)
    );

    assign commit = ev.wr_end;

    pbus_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (commit),
        .addr  (eff_addr),
        .wdata (data_s),
        .rdata (rdata)
    );

    assign data_o     = rdata;
    assign data_oe_o  = ctl_s[C_SEL] & ctl_s[C_RD];
    assign mode_o     = (mode == BUS_MUXED);
    assign reg_addr_o = eff_addr;
    assign wr_data_o  = data_s;
    assign wr_pulse_o = commit;
endmodule

// File: rtl/pbus_slave_chk.sv
module pbus_slave_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              ale_i,
    input logic              cs_n_i,
    input logic              rd_n_i,
    input logic              wr_n_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              data_oe_o,
    input logic              mode_o,
    input logic [ADDR_W-1:0] reg_addr_o,
    input logic              wr_pulse_o
);
    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (rst)
        wr_pulse_o |=> !wr_pulse_o);

    assert_write_needs_select_R8: assert property (@(posedge clk) disable iff (rst)
        wr_pulse_o |-> $past(!cs_n_i, 2));

    assert_drive_needs_read_R9: assert property (@(posedge clk) disable iff (rst)
        data_oe_o |-> ($past(!cs_n_i, 2) && $past(!rd_n_i, 2)));

    assert_muxed_after_ale_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_o) |-> $past(ale_i, 3));

    assert_direct_after_release_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(mode_o) |-> $past(cs_n_i, 3));

    assert_direct_address_R2: assert property (@(posedge clk) disable iff (rst)
        (!mode_o && !$past(rst, 1) && !$past(rst, 2)) |-> (reg_addr_o == $past(addr_i, 2)));
endmodule

bind pbus_slave pbus_slave_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ale_i      (ale_i),
    .cs_n_i     (cs_n_i),
    .rd_n_i     (rd_n_i),
    .wr_n_i     (wr_n_i),
    .addr_i     (addr_i),
    .data_oe_o  (data_oe_o),
    .mode_o     (mode_o),
    .reg_addr_o (reg_addr_o),
    .wr_pulse_o (wr_pulse_o)
);

// File: tb/test_pbus_slave.sv
module test_pbus_slave;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ale = 1'b0;
    logic       cs_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [3:0] addr = 4'h0;
    logic [7:0] dq = 8'h00;
    logic [7:0] data_o, wr_data_o;
    logic [3:0] reg_addr_o;
    logic       data_oe_o, mode_o, wr_pulse_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pbus_slave i_pbus_slave (
        .clk(clk), .rst(rst), .ale_i(ale), .cs_n_i(cs_n), .rd_n_i(rd_n),
        .wr_n_i(wr_n), .addr_i(addr), .data_i(dq), .data_o(data_o),
        .data_oe_o(data_oe_o), .mode_o(mode_o), .reg_addr_o(reg_addr_o),
        .wr_data_o(wr_data_o), .wr_pulse_o(wr_pulse_o)
    );

    // ---- behavioural reference: pin history queue, integers, byte array
    // packing: [15] ale, [14] select, [13] read, [12] write, [11:8] addr, [7:0] data
    logic [15:0] hist [$];
    int          m_mode;
    int          m_lat;
    int          m_mem [16];

    function automatic logic [15:0] pins_now();
        return {ale, ~cs_n, ~rd_n, ~wr_n, addr, dq};
    endfunction

    function automatic int m_addr();
        return (m_mode == 1) ? m_lat : int'(hist[1][11:8]);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            hist = {16'h0, 16'h0, 16'h0};
            m_mode = 0;
            m_lat = 0;
            foreach (m_mem[i]) m_mem[i] = 0;
        end else begin
            logic [15:0] now_v, was_v;
            now_v = hist[1];
            was_v = hist[2];
            if (now_v[14] && was_v[12] && !now_v[12])
                m_mem[m_addr()] = int'(now_v[7:0]);
            if (!now_v[15] && was_v[15])
                m_lat = int'(now_v[3:0]);
            if (now_v[15] && !was_v[15])       m_mode = 1;
            else if (!now_v[14] && was_v[14])  m_mode = 0;
            hist.push_front(pins_now());
            void'(hist.pop_back());
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison with the model
    always @(negedge clk) begin
        if (!rst && hist.size() == 3) begin
            logic [15:0] s;
            bit          exp_oe, exp_pulse;
            s = hist[1];
            exp_oe    = s[14] & s[13];
            exp_pulse = s[14] & hist[2][12] & ~s[12];
            chk(int'(mode_o) == m_mode, "R3/R4 mode", int'(mode_o), m_mode);
            chk(int'(reg_addr_o) == m_addr(), "R2/R5 address", int'(reg_addr_o), m_addr());
            chk(data_oe_o == exp_oe, "R9 output enable", int'(data_oe_o), int'(exp_oe));
            if (exp_oe)
                chk(int'(data_o) == m_mem[m_addr()], "R9 read data", int'(data_o), m_mem[m_addr()]);
            chk(wr_pulse_o == exp_pulse, "R7 write pulse", int'(wr_pulse_o), int'(exp_pulse));
            if (exp_pulse)
                chk(wr_data_o == s[7:0], "R7 write data", int'(wr_data_o), int'(s[7:0]));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic dir_write(input logic [3:0] a, input logic [7:0] d);
        cs_n = 1'b0; addr = a; dq = d; idle(3);
        wr_n = 1'b0; idle(3);
        wr_n = 1'b1; idle(3);
        cs_n = 1'b1; idle(3);
    endtask

    task automatic dir_read(input logic [3:0] a, input logic [7:0] exp, input string req);
        cs_n = 1'b0; rd_n = 1'b0; addr = a; idle(4);
        chk(data_oe_o == 1'b1, req, int'(data_oe_o), 1);
        chk(data_o == exp, req, int'(data_o), int'(exp));
        rd_n = 1'b1; cs_n = 1'b1; idle(3);
    endtask

    task automatic latch_addr(input logic [7:0] a);
        dq = a; ale = 1'b1; idle(3);
        ale = 1'b0; idle(3);
    endtask

    task automatic mux_write(input logic [7:0] a, input logic [7:0] d);
        latch_addr(a);
        cs_n = 1'b0; dq = d; idle(3);
        wr_n = 1'b0; idle(3);
        wr_n = 1'b1; idle(3);
        cs_n = 1'b1; idle(4);
    endtask

    task automatic mux_read(input logic [7:0] a, input logic [7:0] exp, input string req);
        latch_addr(a);
        dq = 8'h00; cs_n = 1'b0; rd_n = 1'b0; idle(4);
        chk(mode_o == 1'b1, req, int'(mode_o), 1);
        chk(data_oe_o == 1'b1, req, int'(data_oe_o), 1);
        chk(data_o == exp, req, int'(data_o), int'(exp));
        rd_n = 1'b1; cs_n = 1'b1; idle(4);
    endtask

    initial begin
        int cnt;
        cnt = 0;
        while (!done && cnt < 100000) begin
            @(posedge clk);
            cnt++;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(4);
        // R1: reset state
        chk(mode_o == 1'b0, "R1 mode", int'(mode_o), 0);
        chk(data_oe_o == 1'b0, "R1 oe", int'(data_oe_o), 0);
        chk(wr_pulse_o == 1'b0, "R1 pulse", int'(wr_pulse_o), 0);
        rst = 1'b0;
        idle(3);
        dir_read(4'h9, 8'h00, "R1 register cleared");

        // R2: direct mode with latch enable held low
        dir_write(4'h3, 8'h5A);
        dir_write(4'hC, 8'hC3);
        addr = 4'hB; idle(3);
        chk(reg_addr_o == 4'hB, "R2 address follows pins", int'(reg_addr_o), 'hB);
        chk(mode_o == 1'b0, "R2 stays direct", int'(mode_o), 0);
        dir_read(4'h3, 8'h5A, "R7 direct write readback");
        dir_read(4'hC, 8'hC3, "R7 direct write readback");

        // R10: enable latency
        addr = 4'h3; cs_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        chk(data_oe_o == 1'b0, "R10 oe after one edge", int'(data_oe_o), 0);
        @(negedge clk);
        chk(data_oe_o == 1'b1, "R10 oe after two edges", int'(data_oe_o), 1);
        rd_n = 1'b1; idle(3);
        chk(data_oe_o == 1'b0, "R9 oe drops with read", int'(data_oe_o), 0);
        cs_n = 1'b1; idle(3);

        // R8: write strobe without select
        addr = 4'h3; dq = 8'hEE;
        wr_n = 1'b0; idle(3);
        wr_n = 1'b1; idle(3);
        dir_read(4'h3, 8'h5A, "R8 unselected write ignored");

        // R3 / R6: latch enable with chip select high; upper data bits ignored (R5)
        ale = 1'b1; dq = 8'hA7; idle(1);
        chk(mode_o == 1'b0, "R3 not yet muxed", int'(mode_o), 0);
        idle(2);
        chk(mode_o == 1'b1, "R3 muxed after ale rise", int'(mode_o), 1);
        ale = 1'b0; idle(4);
        chk(reg_addr_o == 4'h7, "R5 R6 latched low nibble", int'(reg_addr_o), 7);

        // R4: chip-select release returns to direct
        cs_n = 1'b0; idle(3);
        cs_n = 1'b1; addr = 4'h2; idle(4);
        chk(mode_o == 1'b0, "R4 direct after release", int'(mode_o), 0);
        chk(reg_addr_o == 4'h2, "R2 pins after release", int'(reg_addr_o), 2);

        // multiplexed traffic
        mux_write(8'hF1, 8'h11);
        mux_write(8'h0E, 8'hE7);
        mux_read(8'h31, 8'h11, "R5 muxed readback");
        mux_read(8'h0E, 8'hE7, "R5 muxed readback");
        mux_read(8'h93, 8'h5A, "R5 muxed reads direct-written reg");
        dir_read(4'h1, 8'h11, "R7 muxed write seen in direct mode");

        // R4 priority: ale rise and select release on the same edge
        cs_n = 1'b0; idle(4);
        ale = 1'b1; cs_n = 1'b1; dq = 8'h04; idle(4);
        chk(mode_o == 1'b1, "R4 ale rise wins", int'(mode_o), 1);
        ale = 1'b0; idle(3);
        cs_n = 1'b0; idle(3);
        cs_n = 1'b1; idle(4);
        chk(mode_o == 1'b0, "R4 release afterwards", int'(mode_o), 0);

        idle(5);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule